// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver

This block receives bytes over a two-wire synchronous link: an external serial clock and a serial data line. Both wires are brought into the system clock domain through a synchronizer chain. A rising edge of the serial clock samples one data bit. Bits arrive least significant first. When the last bit of a frame has been sampled, the assembled word is moved into a receive holding register, and a data-ready flag is raised.

Software or a transfer engine then collects the word. Software reads the holding register and clears the ready flag through the status register. A transfer engine clears the flag with a one-cycle acknowledge pulse. If the ready flag is still set when the final bit of the next frame is sampled, that new word is dropped and an overrun flag is set. While an overrun, parity-error or framing-error flag is pending, reception is suspended. The parity and framing flags are only set from outside the block, through two set pulses.

The status flags follow a read-then-clear protocol. A flag is cleared only by writing 0 to its bit after a status read has returned that bit as 1. Two interrupt lines are provided: a data-ready request and an error request. Each one is gated by its own enable bit.

Top module: `csrx_receiver`

## Requirements
- R1: Each frame is DATA_W bits, sampled on rising serial-clock edges, least significant bit first. When the last bit is sampled, the word appears at register address 2 and status bit 0 (data ready) is set.
- R2: While status bit 1 (overrun) is set, frames are ignored: data ready stays clear and address 2 keeps its value. Reception resumes once overrun is cleared.
- R3: While status bit 2 (parity error) or status bit 3 (framing error) is set, no frame is taken and data ready never rises. These bits are set by one-cycle pulses on err_par_set and err_frm_set.
- R4: If data ready is still set when the last bit of a frame is sampled, overrun is set and address 2 keeps the earlier unread word.
- R5: A status flag clears only when 0 is written to its bit at address 1 after a read of address 1 returned that bit as 1. Writing 1 to the bit, or writing 0 without a prior read, leaves the flag unchanged.
- R6: rxi_irq equals data ready AND control bit 1, so it rises when data ready goes from 0 to 1.
- R7: A one-cycle pulse on dma_ack clears data ready, with no register write.
- R8: Control bit 0 (receive enable) at 0 stops reception. Bits already shifted into a partial frame are discarded, and the next frame starts from bit 0.
- R9: eri_irq equals overrun AND control bit 2.
- R10: After reset, the control, status and data registers read 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | External serial clock, asynchronous |
| ser_data | input | 1 | Serial data, valid around serial clock rising edges |
| err_par_set | input | 1 | Pulse that sets the parity-error flag |
| err_frm_set | input | 1 | Pulse that sets the framing-error flag |
| dma_ack | input | 1 | Transfer-engine acknowledge, clears data ready |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| rxi_irq | output | 1 | Data-ready interrupt request |
| eri_irq | output | 1 | Overrun interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 3. The deeper synchronizer exercises the generated chain beyond its minimum length and adds one cycle of latency between the serial edge and the sample. The serial clock is held for four system cycles per phase. This makes the sample point fall clearly inside the high phase. It also lets the bench clear or leave the data-ready flag before the final bit of the next frame, which covers both overrun and back-to-back reception.

// File: rtl/csrx_pkg.sv
`timescale 1ns/1ps
package csrx_pkg;
   localparam int NUM_FLAGS = 4;
   localparam int REG_AW    = 2;

   typedef enum logic [REG_AW-1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_DATA = 2'd2
   } reg_addr_e;

   // control bit positions
   localparam int CTL_EN   = 0;
   localparam int CTL_RXIE = 1;
   localparam int CTL_ERIE = 2;

   // status bit positions
   localparam int ST_FULL = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_PERR = 2;
   localparam int ST_FERR = 3;
endpackage

// File: rtl/csrx_sync.sv
`timescale 1ns/1ps
module csrx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_data,
   output logic rise,
   output logic bit_o
);
   // each stage carries {serial clock, serial data}
   logic [1:0] stg [STAGES];
   logic       clk_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= {ser_clk, ser_data};
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[g] <= '0;
         else        stg[g] <= stg[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_last <= 1'b0;
      else        clk_last <= stg[STAGES-1][1];
   end

   assign rise  = stg[STAGES-1][1] & ~clk_last;
   assign bit_o = stg[STAGES-1][0];
endmodule

// File: rtl/csrx_shifter.sv
`timescale 1ns/1ps
module csrx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rise,
   input  logic              bit_i,
   output logic              done,
   output logic [DATA_W-1:0] frame
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (rise) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         sh  <= {bit_i, sh[DATA_W-2:1]};
      end
   end

   assign done  = run & rise & (cnt == LAST);
   assign frame = {bit_i, sh};
endmodule

// File: rtl/csrx_regs.sv
`timescale 1ns/1ps
module csrx_regs
   import csrx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [NUM_FLAGS-1:0] reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic                 done,
   input  logic [DATA_W-1:0]    frame,
   input  logic                 perr_set,
   input  logic                 ferr_set,
   input  logic                 dma_ack,
   output logic [2:0]           ctrl,
   output logic [NUM_FLAGS-1:0] flags,
   output logic [DATA_W-1:0]    rdr
);
   logic [NUM_FLAGS-1:0] armed, sw_clr;
   logic wr_stat, rd_stat, accept, overrun;

   assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
   assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
   assign sw_clr  = wr_stat ? (armed & ~reg_wdata) : '0;
   assign accept  = done && !flags[ST_FULL];
   assign overrun = done &&  flags[ST_FULL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         flags <= '0;
         armed <= '0;
         rdr   <= '0;
      end else begin
         if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= reg_wdata[2:0];
         if (accept) rdr <= frame;

         if (accept)                          flags[ST_FULL] <= 1'b1;
         else if (sw_clr[ST_FULL] || dma_ack) flags[ST_FULL] <= 1'b0;

         if (overrun)             flags[ST_OVR] <= 1'b1;
         else if (sw_clr[ST_OVR]) flags[ST_OVR] <= 1'b0;

         if (perr_set)             flags[ST_PERR] <= 1'b1;
         else if (sw_clr[ST_PERR]) flags[ST_PERR] <= 1'b0;

         if (ferr_set)             flags[ST_FERR] <= 1'b1;
         else if (sw_clr[ST_FERR]) flags[ST_FERR] <= 1'b0;

         armed <= (armed & ~sw_clr) | (rd_stat ? flags : '0);
      end
   end

   always_comb begin
      unique case (reg_addr)
         ADDR_CTRL: reg_rdata = DATA_W'(ctrl);
         ADDR_STAT: reg_rdata = DATA_W'(flags);
         ADDR_DATA: reg_rdata = rdr;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/csrx_receiver.sv
`timescale 1ns/1ps
module csrx_receiver
   import csrx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_data,
   input  logic                 err_par_set,
   input  logic                 err_frm_set,
   input  logic                 dma_ack,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [NUM_FLAGS-1:0] reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 rxi_irq,
   output logic                 eri_irq
);
   if (DATA_W < NUM_FLAGS) begin : g_bad_width
      $error("csrx_receiver: DATA_W must be at least %0d", NUM_FLAGS);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("csrx_receiver: SYNC_STAGES must be at least 2");
   end

   logic                 s_rise, s_bit, run, frm_done;
   logic [DATA_W-1:0]    frm_word, rdr;
   logic [2:0]           ctrl;
   logic [NUM_FLAGS-1:0] flags;

   csrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .rise(s_rise), .bit_o(s_bit)
   );

   assign run = ctrl[CTL_EN] & ~flags[ST_OVR] & ~flags[ST_PERR] & ~flags[ST_FERR];

   csrx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .run(run), .rise(s_rise), .bit_i(s_bit),
      .done(frm_done), .frame(frm_word)
   );

   csrx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .done(frm_done), .frame(frm_word), .perr_set(err_par_set),
      .ferr_set(err_frm_set), .dma_ack(dma_ack), .ctrl(ctrl),
      .flags(flags), .rdr(rdr)
   );

   assign rxi_irq = flags[ST_FULL] & ctrl[CTL_RXIE];
   assign eri_irq = flags[ST_OVR]  & ctrl[CTL_ERIE];
endmodule

module csrx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              full,
   input logic              ovr,
   input logic              perr,
   input logic              ferr,
   input logic              rx_en,
   input logic              dma_ack,
   input logic [DATA_W-1:0] rdr
);
   AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(done)); // R1
   AST_OVR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> !$rose(full)); // R2
   AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (perr || ferr) |=> !$rose(full)); // R3
   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $stable(rdr)); // R4
   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(full)); // R4
   AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack && !done) |=> !full); // R7
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !$rose(full)); // R8
endmodule

bind csrx_receiver csrx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(frm_done),
   .full(flags[csrx_pkg::ST_FULL]), .ovr(flags[csrx_pkg::ST_OVR]),
   .perr(flags[csrx_pkg::ST_PERR]), .ferr(flags[csrx_pkg::ST_FERR]),
   .rx_en(ctrl[csrx_pkg::CTL_EN]), .dma_ack(dma_ack), .rdr(rdr)
);

// File: tb/csrx_receiver_tb.sv
`timescale 1ns/1ps
module csrx_receiver_tb;
   import csrx_pkg::*;

   localparam int DATA_W = 8;

   logic       clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0, dma_ack = 1'b0;
   logic       perr_set = 1'b0, ferr_set = 1'b0;
   logic [1:0] reg_addr = ADDR_DATA;
   logic [3:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic       rxi_irq, eri_irq;

   int   n_chk = 0, n_fail = 0;
   bit   mon_en = 1'b0;
   logic [DATA_W-1:0] exp_q [$];
   logic [DATA_W-1:0] d;

   always #2.5 clk = ~clk;

   csrx_receiver #(.DATA_W(DATA_W), .SYNC_STAGES(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_data(sdat),
      .err_par_set(perr_set), .err_frm_set(ferr_set), .dma_ack(dma_ack),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rxi_irq(rxi_irq), .eri_irq(eri_irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] a, logic [3:0] v);
      @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0; reg_addr = ADDR_DATA;
   endtask

   task automatic reg_read(logic [1:0] a, output logic [DATA_W-1:0] v);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0; reg_addr = ADDR_DATA;
   endtask

   task automatic send_bits(logic [DATA_W-1:0] v, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sdat = v[i];
         repeat (4) @(negedge clk); sclk = 1'b1;
         repeat (4) @(negedge clk); sclk = 1'b0;
      end
   endtask

   // driver: pushes the expected word when asked, then shifts it out
   task automatic send_byte(logic [DATA_W-1:0] v, bit push);
      if (push) exp_q.push_back(v);
      send_bits(v, DATA_W);
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse(bit which);
      @(negedge clk); if (which) ferr_set = 1'b1; else perr_set = 1'b1;
      @(negedge clk); ferr_set = 1'b0; perr_set = 1'b0;
   endtask

   // monitor: on a data-ready request, compare and acknowledge like a transfer engine
   always @(negedge clk) begin
      if (dma_ack) dma_ack <= 1'b0;
      else if (mon_en && rxi_irq) begin
         if (exp_q.size() == 0) check("R1 unexpected frame", 1, 0);
         else check("R1/R6 received word", reg_rdata, exp_q.pop_front());
         dma_ack <= 1'b1;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      reg_read(ADDR_CTRL, d); check("R10 ctrl", d, 0);
      reg_read(ADDR_STAT, d); check("R10 status", d, 0);
      reg_read(ADDR_DATA, d); check("R10 data", d, 0);
      check("R10 rxi_irq", rxi_irq, 0);
      check("R10 eri_irq", eri_irq, 0);

      // R1 R6 R7 stream with transfer-engine acknowledge
      reg_write(ADDR_CTRL, 4'b0011);
      mon_en = 1'b1;
      send_byte(8'hA5, 1); send_byte(8'h3C, 1); send_byte(8'h01, 1);
      send_byte(8'hFF, 1); send_byte(8'h80, 1);
      repeat (10) @(negedge clk);
      check("R1 all frames seen", exp_q.size(), 0);
      mon_en = 1'b0;
      reg_read(ADDR_STAT, d); check("R7 ready cleared by ack", d, 0);

      // R6 interrupt gating
      reg_write(ADDR_CTRL, 4'b0001);
      send_byte(8'h5A, 0);
      check("R6 masked rxi", rxi_irq, 0);
      reg_read(ADDR_STAT, d); check("R1 ready set", d, 1);
      reg_read(ADDR_DATA, d); check("R1 data", d, 8'h5A);
      reg_write(ADDR_CTRL, 4'b0011); check("R6 enabled rxi", rxi_irq, 1);
      reg_write(ADDR_CTRL, 4'b0001);

      // R4 overrun
      send_byte(8'h77, 0);
      reg_read(ADDR_STAT, d); check("R4 overrun status", d, 3);
      reg_read(ADDR_DATA, d); check("R4 data kept", d, 8'h5A);
      check("R9 eri masked", eri_irq, 0);
      reg_write(ADDR_CTRL, 4'b0101); check("R9 eri enabled", eri_irq, 1);

      // R5 write 1 has no effect, R2 overrun blocks reception
      reg_write(ADDR_STAT, 4'b1110);
      reg_read(ADDR_STAT, d); check("R5 only written-0 bit cleared", d, 2);
      send_byte(8'h11, 0);
      reg_read(ADDR_STAT, d); check("R2 blocked status", d, 2);
      reg_read(ADDR_DATA, d); check("R2 blocked data", d, 8'h5A);
      reg_write(ADDR_STAT, 4'b0000);
      check("R9 eri drops", eri_irq, 0);
      reg_read(ADDR_STAT, d); check("R5 overrun cleared", d, 0);
      send_byte(8'h22, 0);
      reg_read(ADDR_STAT, d); check("R2 resumed status", d, 1);
      reg_read(ADDR_DATA, d); check("R2 resumed data", d, 8'h22);
      reg_write(ADDR_STAT, 4'b0000);
      reg_read(ADDR_STAT, d); check("R5 ready cleared", d, 0);

      // R5 write 0 without prior read
      send_byte(8'h33, 0);
      reg_write(ADDR_STAT, 4'b0000);
      reg_read(ADDR_STAT, d); check("R5 unarmed clear ignored", d, 1);
      reg_write(ADDR_STAT, 4'b0000);

      // R3 parity and framing flags gate reception
      pulse(0);
      send_byte(8'h44, 0);
      reg_read(ADDR_STAT, d); check("R3 parity gate", d, 4);
      reg_read(ADDR_DATA, d); check("R3 data kept", d, 8'h33);
      reg_write(ADDR_STAT, 4'b0000);
      pulse(1);
      send_byte(8'h45, 0);
      reg_read(ADDR_STAT, d); check("R3 framing gate", d, 8);
      reg_write(ADDR_STAT, 4'b0000);
      send_byte(8'h46, 0);
      reg_read(ADDR_STAT, d); check("R3 resumed status", d, 1);
      reg_read(ADDR_DATA, d); check("R3 resumed data", d, 8'h46);
      reg_write(ADDR_STAT, 4'b0000);

      // R8 enable dropped mid-frame discards partial bits
      send_bits(8'hFF, 4);
      reg_write(ADDR_CTRL, 4'b0000);
      reg_write(ADDR_CTRL, 4'b0001);
      send_byte(8'h9C, 0);
      reg_read(ADDR_STAT, d); check("R8 realigned status", d, 1);
      reg_read(ADDR_DATA, d); check("R8 realigned data", d, 8'h9C);
      reg_write(ADDR_STAT, 4'b0000);
      reg_write(ADDR_CTRL, 4'b0000);
      send_byte(8'h6B, 0);
      reg_read(ADDR_STAT, d); check("R8 disabled status", d, 0);
      reg_read(ADDR_DATA, d); check("R8 disabled data", d, 8'h9C);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule